// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a bank of 32-bit control and status words mapped into a 4 KiB window. A simple single-cycle bus reaches it: the block takes one read strobe, one write strobe and a word address. Most writable words are guarded by a lock. The bank leaves reset locked. Software opens it by writing a 16-bit magic value to an unlock key word, and closes it again by writing a different magic value to a lock key word. While the bank is locked, writes to guarded words are dropped without complaint.

Every mapped word has an access class: read-only, write-only or read-write. Any other offset is unmapped. A write to a read-only or unmapped offset, or a read of a write-only or unmapped offset, counts as an invalid access. It raises a one-cycle error pulse and sets a sticky error bit, which a dedicated clear input resets. An accepted write that sets bit 0 of the reset-control word raises a one-cycle system reset request.

Only mapped words use storage. Each guarded word has its own slot, and the read-only words are constants. The lock state machine has two states. ST_LOCKED is the reset state. ST_OPEN is entered through transition OPEN_ON_KEY, a write of the unlock key while in ST_LOCKED. ST_LOCKED is re-entered through transition CLOSE_ON_KEY, a write of the lock key while in ST_OPEN. Every other write leaves the state as it is.

Top module: `sysctl_bank`

## Requirements
- R1: After reset the bank holds these values:
  - 0x0001A008 at byte offsets 0x100, 0x104 and 0x108.
  - 0x00014000 at 0x110, 0x114 and 0x118.
  - 0x00000040 at 0x250.
  - 0 at 0x200, 0x60C and 0x614, and 0 in the bit-0 scratch word.
  - err_pulse, err_sticky, sys_rst_req and rd_data are all 0.
- R2: Offset 0x00C is read-only. Bit 0 reads 1 while the bank is locked and 0 while it is open, and the upper bits read 0. The bank comes out of reset locked.
- R3: A write to offset 0x008 whose bits [15:0] equal 0xDF0D opens the bank from the next cycle on; bits [31:16] are ignored. Any other value leaves the lock state unchanged.
- R4: A write to offset 0x004 whose bits [15:0] equal 0x767B locks the bank from the next cycle on. Any other value leaves the lock state unchanged.
- R5: While the bank is locked, writes to the guarded words (0x100-0x108, 0x110-0x118, 0x200, 0x250, 0x60C, 0x614) are dropped with no error. While it is open, they are stored.
- R6: Offset 0x000 keeps only bit 0 of the written data, whatever the lock state. It reads back with bits [31:1] at 0.
- R7: Offsets 0x10C, 0x25C and 0x530 are read-only constants that read 0x3F, 0x1 and the ID_VALUE parameter. A write to any of them is flagged invalid and changes nothing.
- R8: A write to an unmapped offset is flagged invalid and changes no state. A read of an unmapped offset is flagged invalid and returns 0.
- R9: Offsets 0x004, 0x008, 0x60C and 0x614 are write-only, and reading any of them is flagged invalid. Reads of the two key words return 0. Reads of 0x60C and 0x614 return the stored word.
- R10: Read data appears on rd_data in the cycle after the read strobe and is held until the next read.
- R11: err_pulse is high for exactly the cycle after each cycle that holds an invalid access. err_sticky rises with it and stays high until err_clr is asserted. When a clear and a new invalid access fall in the same cycle, err_sticky stays 1.
- R12: An accepted write to offset 0x200 with bit 0 set makes sys_rst_req high for exactly the next cycle, and the value is stored at the same edge. A locked write, or a write with bit 0 clear, gives no request.
- R13: When a read and a write strike the same offset in the same cycle, the read returns the value held before the write, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 10 | Word address, byte address bits [11:2] |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| err_clr | input | 1 | Clears the sticky error bit |
| rd_data | output | 32 | Registered read data |
| err_pulse | output | 1 | One-cycle invalid-access pulse |
| err_sticky | output | 1 | Sticky invalid-access flag |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
Two functions can fall in the same cycle: clearing the sticky error bit and raising a new invalid access. The bench provokes this by asserting err_clr in the same cycle as a write to an unmapped offset. It judges the result by err_sticky staying at 1 while err_pulse fires. A second overlap is a read and a write to the same guarded word in one cycle. The bench requires the old value on rd_data and the new value on the following read.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int ADDR_W    = 12;
    localparam int WORD_W    = ADDR_W - 2;
    localparam int DATA_W    = 32;
    localparam int NUM_SLOTS = 10;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    // word indices (byte offset / 4)
    localparam logic [WORD_W-1:0] W_SCRATCH = 10'h000;
    localparam logic [WORD_W-1:0] W_LOCK    = 10'h001;
    localparam logic [WORD_W-1:0] W_UNLOCK  = 10'h002;
    localparam logic [WORD_W-1:0] W_LSTAT   = 10'h003;
    localparam logic [WORD_W-1:0] W_PLLC0   = 10'h040;
    localparam logic [WORD_W-1:0] W_PLLST   = 10'h043;
    localparam logic [WORD_W-1:0] W_PLLG0   = 10'h044;
    localparam logic [WORD_W-1:0] W_RSTCTL  = 10'h080;
    localparam logic [WORD_W-1:0] W_RSTWHY  = 10'h094;
    localparam logic [WORD_W-1:0] W_BOOT    = 10'h097;
    localparam logic [WORD_W-1:0] W_IDENT   = 10'h14C;
    localparam logic [WORD_W-1:0] W_CMDA    = 10'h183;
    localparam logic [WORD_W-1:0] W_CMDB    = 10'h185;

    typedef enum logic [1:0] {ACC_UNMAP, ACC_RO, ACC_WO, ACC_RW} acc_e;

    typedef enum logic [2:0] {
        K_NONE, K_SCRATCH, K_LOCKKEY, K_UNLOCKKEY, K_LSTAT, K_CONST, K_SLOT
    } kind_e;

    typedef struct packed {
        acc_e              acc;
        kind_e             kind;
        logic [SLOT_W-1:0] slot;
        logic [DATA_W-1:0] cval;
    } dec_t;

    // slot map: 0-2 PLL control, 3-5 PLL config, 6 reset control,
    // 7 reset reason, 8-9 command triggers
    localparam int S_RSTCTL = 6;

    function automatic logic [DATA_W-1:0] slot_init(input int idx);
        if (idx < 3)      return 32'h0001_A008;
        else if (idx < 6) return 32'h0001_4000;
        else if (idx == 7) return 32'h0000_0040;
        else              return '0;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h5C0F_1D01
) (
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    always_comb begin
        dec = '{acc: ACC_UNMAP, kind: K_NONE, slot: '0, cval: '0};
        unique case (word)
            W_SCRATCH: begin dec.acc = ACC_RW; dec.kind = K_SCRATCH;   end
            W_LOCK:    begin dec.acc = ACC_WO; dec.kind = K_LOCKKEY;   end
            W_UNLOCK:  begin dec.acc = ACC_WO; dec.kind = K_UNLOCKKEY; end
            W_LSTAT:   begin dec.acc = ACC_RO; dec.kind = K_LSTAT;     end
            W_PLLST:   begin dec.acc = ACC_RO; dec.kind = K_CONST; dec.cval = 32'h3F; end
            W_BOOT:    begin dec.acc = ACC_RO; dec.kind = K_CONST; dec.cval = 32'h1;  end
            W_IDENT:   begin dec.acc = ACC_RO; dec.kind = K_CONST; dec.cval = ID_VALUE; end
            10'h040, 10'h041, 10'h042: begin
                dec.acc = ACC_RW; dec.kind = K_SLOT;
                dec.slot = SLOT_W'(word - W_PLLC0);
            end
            10'h044, 10'h045, 10'h046: begin
                dec.acc = ACC_RW; dec.kind = K_SLOT;
                dec.slot = SLOT_W'(word - W_PLLG0 + 10'd3);
            end
            W_RSTCTL:  begin dec.acc = ACC_RW; dec.kind = K_SLOT; dec.slot = SLOT_W'(S_RSTCTL); end
            W_RSTWHY:  begin dec.acc = ACC_RW; dec.kind = K_SLOT; dec.slot = SLOT_W'(7); end
            W_CMDA:    begin dec.acc = ACC_WO; dec.kind = K_SLOT; dec.slot = SLOT_W'(8); end
            W_CMDB:    begin dec.acc = ACC_WO; dec.kind = K_SLOT; dec.slot = SLOT_W'(9); end
            default: ;
        endcase
    end
endmodule

// File: rtl/sysctl_lock_fsm.sv
module sysctl_lock_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic unlock_hit,
    input  logic lock_hit,
    output logic locked
);
    typedef enum logic {ST_LOCKED, ST_OPEN} lock_st_e;
    lock_st_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOCKED: if (unlock_hit) state_nx = ST_OPEN;   // OPEN_ON_KEY
            ST_OPEN:   if (lock_hit)   state_nx = ST_LOCKED; // CLOSE_ON_KEY
            default:   state_nx = ST_LOCKED;
        endcase
    end

    always_comb begin
        locked = (state == ST_LOCKED);
    end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
    import sysctl_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [SLOT_W-1:0]                  wr_slot,
    input  logic [DATA_W-1:0]                  wr_data,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]   slot_q
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam logic [DATA_W-1:0] INIT = slot_init(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= INIT;
            else if (wr_en && (wr_slot == SLOT_W'(g)))
                slot_q[g] <= wr_data;
        end
    end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter logic [15:0]       LOCK_KEY   = 16'h767B,
    parameter logic [15:0]       UNLOCK_KEY = 16'hDF0D,
    parameter logic [DATA_W-1:0] ID_VALUE   = 32'h5C0F_1D01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:2] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_pulse,
    output logic              err_sticky,
    output logic              sys_rst_req
);
    dec_t dec;
    logic lock_q;
    logic scratch_q;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q;

    sysctl_decode #(.ID_VALUE(ID_VALUE)) i_decode (
        .word (bus_addr),
        .dec  (dec)
    );

    logic unlock_hit, lock_hit;
    assign unlock_hit = bus_wr && dec.kind == K_UNLOCKKEY && bus_wdata[15:0] == UNLOCK_KEY;
    assign lock_hit   = bus_wr && dec.kind == K_LOCKKEY   && bus_wdata[15:0] == LOCK_KEY;

    sysctl_lock_fsm i_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .unlock_hit (unlock_hit),
        .lock_hit   (lock_hit),
        .locked     (lock_q)
    );

    logic slot_wr;
    assign slot_wr = bus_wr && dec.kind == K_SLOT && !lock_q;

    sysctl_store i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (slot_wr),
        .wr_slot (dec.slot),
        .wr_data (bus_wdata),
        .slot_q  (slot_q)
    );

    logic wr_bad, rd_bad, err_now;
    assign wr_bad  = bus_wr && (dec.acc == ACC_UNMAP || dec.acc == ACC_RO);
    assign rd_bad  = bus_rd && (dec.acc == ACC_UNMAP || dec.acc == ACC_WO);
    assign err_now = wr_bad || rd_bad;

    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        unique case (dec.kind)
            K_SCRATCH: rd_mux = {{(DATA_W-1){1'b0}}, scratch_q};
            K_LSTAT:   rd_mux = {{(DATA_W-1){1'b0}}, lock_q};
            K_CONST:   rd_mux = dec.cval;
            K_SLOT:    rd_mux = slot_q[dec.slot];
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scratch_q   <= 1'b0;
            rd_data     <= '0;
            err_pulse   <= 1'b0;
            err_sticky  <= 1'b0;
            sys_rst_req <= 1'b0;
        end else begin
            if (bus_wr && dec.kind == K_SCRATCH) scratch_q <= bus_wdata[0];
            if (bus_rd) rd_data <= rd_mux;
            err_pulse   <= err_now;
            err_sticky  <= err_now || (err_sticky && !err_clr);
            sys_rst_req <= slot_wr && dec.slot == SLOT_W'(S_RSTCTL) && bus_wdata[0];
        end
    end
endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk
    import sysctl_pkg::*;
#(
    parameter logic [15:0] LOCK_KEY   = 16'h767B,
    parameter logic [15:0] UNLOCK_KEY = 16'hDF0D
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:2] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              err_clr,
    input logic              err_pulse,
    input logic              err_sticky,
    input logic              sys_rst_req,
    input logic              lock_q,
    input logic [DATA_W-1:0] pll0_q
);
    // R3
    unlock_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == W_UNLOCK && bus_wdata[15:0] == UNLOCK_KEY) |=> !lock_q);

    // R3
    wrong_key_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == W_UNLOCK && bus_wdata[15:0] != UNLOCK_KEY) |=> $stable(lock_q));

    // R4
    lock_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == W_LOCK && bus_wdata[15:0] == LOCK_KEY) |=> lock_q);

    // R5
    locked_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == W_PLLC0 && lock_q) |=> $stable(pll0_q));

    // R11
    pulse_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> err_sticky);

    // R11
    sticky_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sticky && !err_clr) |=> err_sticky);

    // R12
    rst_req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> $past(bus_wr && bus_addr == W_RSTCTL && bus_wdata[0] && !lock_q));
endmodule

bind sysctl_bank sysctl_bank_chk #(
    .LOCK_KEY   (LOCK_KEY),
    .UNLOCK_KEY (UNLOCK_KEY)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .err_clr     (err_clr),
    .err_pulse   (err_pulse),
    .err_sticky  (err_sticky),
    .sys_rst_req (sys_rst_req),
    .lock_q      (lock_q),
    .pll0_q      (slot_q[0])
);

// File: tb/test_sysctl_bank.sv
`timescale 1ns/1ps
module test_sysctl_bank;

    localparam logic [31:0] ID = 32'h5C0F_1D01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        err_clr = 1'b0;
    logic [31:0] rd_data;
    logic        err_pulse, err_sticky, sys_rst_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sysctl_bank i_sysctl_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .err_clr(err_clr),
        .rd_data(rd_data), .err_pulse(err_pulse), .err_sticky(err_sticky),
        .sys_rst_req(sys_rst_req)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [11:0] addr;
        logic [31:0] wd;
        logic        chk;
        logic [31:0] exp;
        logic        err;
        logic        req;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,12'h00C,32'h0,        1'b1,32'h1,        1'b0,1'b0,4'd2},  // R2
        '{1'b0,1'b1,12'h100,32'h0,        1'b1,32'h0001A008, 1'b0,1'b0,4'd1},  // R1
        '{1'b0,1'b1,12'h108,32'h0,        1'b1,32'h0001A008, 1'b0,1'b0,4'd1},  // R1
        '{1'b0,1'b1,12'h114,32'h0,        1'b1,32'h00014000, 1'b0,1'b0,4'd1},  // R1
        '{1'b0,1'b1,12'h250,32'h0,        1'b1,32'h40,       1'b0,1'b0,4'd1},  // R1
        '{1'b0,1'b1,12'h200,32'h0,        1'b1,32'h0,        1'b0,1'b0,4'd1},  // R1
        '{1'b0,1'b1,12'h10C,32'h0,        1'b1,32'h3F,       1'b0,1'b0,4'd7},  // R7
        '{1'b0,1'b1,12'h25C,32'h0,        1'b1,32'h1,        1'b0,1'b0,4'd7},  // R7
        '{1'b0,1'b1,12'h530,32'h0,        1'b1,ID,           1'b0,1'b0,4'd7},  // R7
        '{1'b1,1'b0,12'h100,32'hDEADBEEF, 1'b0,32'h0,        1'b0,1'b0,4'd5},  // R5
        '{1'b0,1'b1,12'h100,32'h0,        1'b1,32'h0001A008, 1'b0,1'b0,4'd5},  // R5
        '{1'b1,1'b0,12'h000,32'hFFFFFFFE, 1'b0,32'h0,        1'b0,1'b0,4'd6},  // R6
        '{1'b0,1'b1,12'h000,32'h0,        1'b1,32'h0,        1'b0,1'b0,4'd6},  // R6
        '{1'b1,1'b0,12'h000,32'h3,        1'b0,32'h0,        1'b0,1'b0,4'd6},  // R6
        '{1'b0,1'b1,12'h000,32'h0,        1'b1,32'h1,        1'b0,1'b0,4'd6},  // R6
        '{1'b1,1'b0,12'h008,32'h12340000, 1'b0,32'h0,        1'b0,1'b0,4'd3},  // R3
        '{1'b0,1'b1,12'h00C,32'h0,        1'b1,32'h1,        1'b0,1'b0,4'd3},  // R3
        '{1'b1,1'b0,12'h008,32'hABCDDF0D, 1'b0,32'h0,        1'b0,1'b0,4'd3},  // R3
        '{1'b0,1'b1,12'h00C,32'h0,        1'b1,32'h0,        1'b0,1'b0,4'd3},  // R3
        '{1'b1,1'b0,12'h104,32'h11112222, 1'b0,32'h0,        1'b0,1'b0,4'd5},  // R5
        '{1'b0,1'b1,12'h104,32'h0,        1'b1,32'h11112222, 1'b0,1'b0,4'd5},  // R5
        '{1'b1,1'b1,12'h108,32'h00005555, 1'b1,32'h0001A008, 1'b0,1'b0,4'd13}, // R13
        '{1'b0,1'b1,12'h108,32'h0,        1'b1,32'h00005555, 1'b0,1'b0,4'd13}, // R13
        '{1'b1,1'b0,12'h10C,32'h0,        1'b0,32'h0,        1'b1,1'b0,4'd7},  // R7
        '{1'b0,1'b1,12'h10C,32'h0,        1'b1,32'h3F,       1'b0,1'b0,4'd7},  // R7
        '{1'b1,1'b0,12'h7FC,32'h5,        1'b0,32'h0,        1'b1,1'b0,4'd8},  // R8
        '{1'b0,1'b1,12'h7FC,32'h0,        1'b1,32'h0,        1'b1,1'b0,4'd8},  // R8
        '{1'b0,1'b1,12'h004,32'h0,        1'b1,32'h0,        1'b1,1'b0,4'd9},  // R9
        '{1'b1,1'b0,12'h60C,32'hCAFE0001, 1'b0,32'h0,        1'b0,1'b0,4'd9},  // R9
        '{1'b0,1'b1,12'h60C,32'h0,        1'b1,32'hCAFE0001, 1'b1,1'b0,4'd9},  // R9
        '{1'b1,1'b0,12'h200,32'h2,        1'b0,32'h0,        1'b0,1'b0,4'd12}, // R12
        '{1'b1,1'b0,12'h200,32'h1,        1'b0,32'h0,        1'b0,1'b1,4'd12}, // R12
        '{1'b0,1'b1,12'h200,32'h0,        1'b1,32'h1,        1'b0,1'b0,4'd12}, // R12
        '{1'b1,1'b0,12'h004,32'h0000767A, 1'b0,32'h0,        1'b0,1'b0,4'd4},  // R4
        '{1'b0,1'b1,12'h00C,32'h0,        1'b1,32'h0,        1'b0,1'b0,4'd4},  // R4
        '{1'b1,1'b0,12'h004,32'h0000767B, 1'b0,32'h0,        1'b0,1'b0,4'd4},  // R4
        '{1'b0,1'b1,12'h00C,32'h0,        1'b1,32'h1,        1'b0,1'b0,4'd4},  // R4
        '{1'b1,1'b0,12'h200,32'h3,        1'b0,32'h0,        1'b0,1'b0,4'd12}, // R12
        '{1'b0,1'b1,12'h200,32'h0,        1'b1,32'h1,        1'b0,1'b0,4'd12}  // R12
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge with outputs settled
    task automatic step(input logic w, input logic r, input logic [11:0] a,
                        input logic [31:0] d, input logic clr);
        bus_wr = w; bus_rd = r; bus_addr = a[11:2]; bus_wdata = d; err_clr = clr;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; err_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state of the flags and read data
        check("R1 err_sticky", {31'b0, err_sticky}, 32'h0);
        check("R1 err_pulse", {31'b0, err_pulse}, 32'h0);
        check("R1 sys_rst_req", {31'b0, sys_rst_req}, 32'h0);
        check("R1 rd_data", rd_data, 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].wr, VECS[i].rd, VECS[i].addr, VECS[i].wd, 1'b0);
            if (VECS[i].chk)
                check($sformatf("R%0d row %0d rd_data", VECS[i].tag, i), rd_data, VECS[i].exp);
            check($sformatf("R%0d row %0d err_pulse", VECS[i].tag, i),
                  {31'b0, err_pulse}, {31'b0, VECS[i].err});
            check($sformatf("R%0d row %0d sys_rst_req", VECS[i].tag, i),
                  {31'b0, sys_rst_req}, {31'b0, VECS[i].req});
        end

        // R11 sticky held from earlier errors, then cleared
        check("R11 sticky held", {31'b0, err_sticky}, 32'h1);
        step(1'b0, 1'b0, 12'h000, 32'h0, 1'b1);
        check("R11 sticky cleared", {31'b0, err_sticky}, 32'h0);
        check("R11 no pulse on clear", {31'b0, err_pulse}, 32'h0);
        // R11 clear and new error in the same cycle: set wins
        step(1'b1, 1'b0, 12'h7F0, 32'h9, 1'b1);
        check("R11 set wins sticky", {31'b0, err_sticky}, 32'h1);
        check("R11 set wins pulse", {31'b0, err_pulse}, 32'h1);
        step(1'b0, 1'b0, 12'h000, 32'h0, 1'b0);
        check("R11 pulse one cycle", {31'b0, err_pulse}, 32'h0);
        check("R11 sticky stays", {31'b0, err_sticky}, 32'h1);

        // R10 read data held across idle cycles
        step(1'b0, 1'b1, 12'h10C, 32'h0, 1'b0);
        check("R10 read", rd_data, 32'h3F);
        step(1'b0, 1'b0, 12'h100, 32'h0, 1'b0);
        step(1'b0, 1'b0, 12'h104, 32'h0, 1'b0);
        check("R10 held", rd_data, 32'h3F);

        // R12 request lasts one cycle; R9 second command word stored when open
        step(1'b1, 1'b0, 12'h008, 32'h0000DF0D, 1'b0);
        step(1'b1, 1'b0, 12'h200, 32'h1, 1'b0);
        check("R12 request", {31'b0, sys_rst_req}, 32'h1);
        step(1'b0, 1'b0, 12'h000, 32'h0, 1'b0);
        check("R12 single cycle", {31'b0, sys_rst_req}, 32'h0);
        step(1'b1, 1'b0, 12'h614, 32'h0BADF00D, 1'b0);
        step(1'b0, 1'b1, 12'h614, 32'h0, 1'b0);
        check("R9 command word read", rd_data, 32'h0BADF00D);
        check("R9 command read flagged", {31'b0, err_pulse}, 32'h1);
        // R6 scratch writable while locked
        step(1'b1, 1'b0, 12'h004, 32'h0000767B, 1'b0);
        step(1'b1, 1'b0, 12'h000, 32'h0, 1'b0);
        step(1'b0, 1'b1, 12'h000, 32'h0, 1'b0);
        check("R6 scratch write while locked", rd_data, 32'h0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule